// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This block sits between a processor and its memory path. It turns each logical address that a running process issues into a physical address, and it keeps the process inside its own memory partition. Two registers describe that partition. The offset register holds the physical start of the partition. The span register holds the partition's length in addressable units. Both registers can be written only while the privileged-mode input is high. A write made in user mode changes nothing and is reported on a violation output.

For each valid request, the unit compares the logical address with the span. When the address is in range, the unit adds the offset to form the physical address. When the address is out of range, it raises a protection fault and issues no access. The response is registered, so it appears one clock cycle after the request.

Top module: `reloc_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `rsp_fault`, `priv_err` and `rsp_paddr` are all zero. Reset also clears the offset and span registers to zero.
- R2: For an in-range request, `rsp_paddr` in the next cycle equals offset + logical address, zero-extended and taken modulo 2^PHYS_W, with `rsp_valid` high. For example, offset 0x9000 and logical address 0x1204 give 0xA204.
- R3: For a request whose logical address is greater than or equal to the span, the next cycle shows `rsp_fault` high, `rsp_valid` low and `rsp_paddr` zero.
- R4: A logical address exactly equal to the span faults. Span minus one is accepted.
- R5: A privileged write with `cfg_sel`=0 loads the offset from `cfg_wdata`. With `cfg_sel`=1 it loads the span from the low LADDR_W bits of `cfg_wdata`. The new value applies to requests issued in later cycles. A request issued in the same cycle as the write is translated with the old values.
- R6: A write with `priv` low changes neither register, which later translations show. `priv_err` is high for exactly the one cycle after that write, and it is low after any other cycle.
- R7: A cycle with `req_valid` low gives `rsp_valid`, `rsp_fault` and `rsp_paddr` all zero in the next cycle.
- R8: After reset and before any privileged write to the span, every request faults.
- R9: `rsp_valid` and `rsp_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 1 | Privileged mode; permits register writes |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Selects the register: 0 for offset, 1 for span |
| cfg_wdata | input | PHYS_W | Write data |
| req_valid | input | 1 | Request present |
| req_laddr | input | LADDR_W | Logical address |
| rsp_valid | output | 1 | Translated access is valid |
| rsp_paddr | output | PHYS_W | Physical address; zero unless `rsp_valid` is high |
| rsp_fault | output | 1 | Protection fault for the previous request |
| priv_err | output | 1 | A user-mode write was attempted in the previous cycle |

## Verification
The hardest cases to reach are the exact span boundary and the ordering between a register write and a request in the same cycle. Uniformly random addresses almost never land on the span or one below it. The stimulus therefore draws small span values and picks addresses at span-1, span and span+1 with raised probability. It also includes directed cycles that issue a privileged write and a request together, so the old-value rule can be checked against the bench model. User-mode writes are mixed into the random stream at random points, and each one is followed by translations that would expose any change it had made.

// File: rtl/reloc_pkg.sv
`timescale 1ns/1ps
package reloc_pkg;
  typedef enum logic {
    SEL_OFFSET = 1'b0,
    SEL_SPAN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/reloc_regs.sv
`timescale 1ns/1ps
// Partition registers with privilege gate and violation flag.
module reloc_regs #(
  parameter int LADDR_W = 16,
  parameter int PHYS_W  = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               priv,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PHYS_W-1:0]  cfg_wdata,
  output logic [PHYS_W-1:0]  offset_q,
  output logic [LADDR_W-1:0] span_q,
  output logic               viol_q
);
  import reloc_pkg::*;

  reg_sel_e sel;
  logic     wr_ok;

  always_comb begin
    sel   = reg_sel_e'(cfg_sel);
    wr_ok = cfg_we && priv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= '0;
      span_q   <= '0;
      viol_q   <= 1'b0;
    end else begin
      viol_q <= cfg_we && !priv;
      if (wr_ok && sel == SEL_OFFSET) offset_q <= cfg_wdata;
      if (wr_ok && sel == SEL_SPAN)   span_q   <= cfg_wdata[LADDR_W-1:0];
    end
  end
endmodule

// File: rtl/reloc_xlate.sv
`timescale 1ns/1ps
// Combinational range check and relocation adder.
module reloc_xlate #(
  parameter int LADDR_W = 16,
  parameter int PHYS_W  = 20
) (
  input  logic [PHYS_W-1:0]  offset,
  input  logic [LADDR_W-1:0] span,
  input  logic [LADDR_W-1:0] laddr,
  output logic               in_range,
  output logic [PHYS_W-1:0]  paddr
);
  always_comb begin
    in_range = laddr < span;
    paddr    = offset + PHYS_W'(laddr);
  end
endmodule

// File: rtl/reloc_resp.sv
`timescale 1ns/1ps
// Registered response stage; blocks the address on a fault.
module reloc_resp #(
  parameter int PHYS_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              in_range,
  input  logic [PHYS_W-1:0] paddr_d,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PHYS_W-1:0] rsp_paddr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid && in_range;
      rsp_fault <= req_valid && !in_range;
      rsp_paddr <= (req_valid && in_range) ? paddr_d : '0;
    end
  end
endmodule

// File: rtl/reloc_unit.sv
`timescale 1ns/1ps
// Top: base/limit relocation with privileged configuration.
module reloc_unit #(
  parameter int LADDR_W = 16,
  parameter int PHYS_W  = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               priv,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PHYS_W-1:0]  cfg_wdata,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_laddr,
  output logic               rsp_valid,
  output logic [PHYS_W-1:0]  rsp_paddr,
  output logic               rsp_fault,
  output logic               priv_err
);
  logic [PHYS_W-1:0]  offset_q;
  logic [LADDR_W-1:0] span_q;
  logic               in_range;
  logic [PHYS_W-1:0]  paddr_d;

  reloc_regs #(.LADDR_W(LADDR_W), .PHYS_W(PHYS_W)) regs_i (
    .clk(clk), .rst(rst), .priv(priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .offset_q(offset_q), .span_q(span_q),
    .viol_q(priv_err)
  );

  reloc_xlate #(.LADDR_W(LADDR_W), .PHYS_W(PHYS_W)) xlate_i (
    .offset(offset_q), .span(span_q), .laddr(req_laddr),
    .in_range(in_range), .paddr(paddr_d)
  );

  reloc_resp #(.PHYS_W(PHYS_W)) resp_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .in_range(in_range),
    .paddr_d(paddr_d), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );
endmodule

// File: rtl/reloc_unit_chk.sv
`timescale 1ns/1ps
module reloc_unit_chk #(
  parameter int LADDR_W = 16,
  parameter int PHYS_W  = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               priv,
  input logic               cfg_we,
  input logic               req_valid,
  input logic [LADDR_W-1:0] req_laddr,
  input logic               rsp_valid,
  input logic [PHYS_W-1:0]  rsp_paddr,
  input logic               rsp_fault,
  input logic               priv_err,
  input logic [PHYS_W-1:0]  offset_q,
  input logic [LADDR_W-1:0] span_q
);
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_fault));

  p_user_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !priv) |=> priv_err);

  p_flag_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && !priv) |=> !priv_err);

  p_user_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !priv) |=> ($stable(offset_q) && $stable(span_q)));

  p_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_laddr >= span_q) |=> (rsp_fault && !rsp_valid && rsp_paddr == '0));

  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_laddr < span_q) |=>
      (rsp_valid && rsp_paddr == $past(offset_q) + PHYS_W'($past(req_laddr))));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));
endmodule

bind reloc_unit reloc_unit_chk #(.LADDR_W(LADDR_W), .PHYS_W(PHYS_W)) chk_i (
  .clk(clk), .rst(rst), .priv(priv), .cfg_we(cfg_we), .req_valid(req_valid),
  .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .priv_err(priv_err), .offset_q(offset_q),
  .span_q(span_q)
);

// File: tb/reloc_unit_tb_top.sv
`timescale 1ns/1ps
module reloc_unit_tb_top;
  localparam int LW = 16;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          priv = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [PW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_laddr = '0;
  logic          rsp_valid, rsp_fault, priv_err;
  logic [PW-1:0] rsp_paddr;

  int n_chk = 0;
  int n_bad = 0;
  logic [PW-1:0] m_off = '0;
  logic [LW-1:0] m_span = '0;

  always #2.5 clk = ~clk;

  reloc_unit #(.LADDR_W(LW), .PHYS_W(PW)) dut_i (
    .clk(clk), .rst(rst), .priv(priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .priv_err(priv_err)
  );

  function automatic logic [PW-1:0] f_paddr(logic [PW-1:0] o, logic [LW-1:0] a);
    return o + PW'(a);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample just after the next posedge.
  task automatic cycle(logic we, logic pv, logic sel, logic [PW-1:0] wd,
                       logic rv, logic [LW-1:0] la);
    logic exp_ok;
    logic [PW-1:0] exp_pa;
    @(negedge clk);
    cfg_we = we; priv = pv; cfg_sel = sel; cfg_wdata = wd;
    req_valid = rv; req_laddr = la;
    exp_ok = rv && (la < m_span);
    exp_pa = exp_ok ? f_paddr(m_off, la) : '0;
    @(posedge clk); #1;
    if (we && pv) begin
      if (sel) m_span = wd[LW-1:0]; else m_off = wd;
    end
    if (!rv) begin
      check("R7 idle valid", 32'(rsp_valid), 0);
      check("R7 idle fault", 32'(rsp_fault), 0);
    end else begin
      check("R2/R3 valid", 32'(rsp_valid), 32'(exp_ok));
      check("R3 fault", 32'(rsp_fault), 32'(!exp_ok));
    end
    check("R2 paddr", 32'(rsp_paddr), 32'(exp_pa));
    check("R6 priv_err", 32'(priv_err), 32'(we && !pv));
    check("R9 excl", 32'(rsp_valid && rsp_fault), 0);
    cfg_we = 1'b0;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 rst valid", 32'(rsp_valid), 0);
    check("R1 rst fault", 32'(rsp_fault), 0);
    check("R1 rst err", 32'(priv_err), 0);
    check("R1 rst paddr", 32'(rsp_paddr), 0);
    @(negedge clk); rst = 1'b0;
    // R8: unprogrammed span faults every request
    cycle(0, 0, 0, 0, 1, 16'h0000);
    cycle(0, 0, 0, 0, 1, 16'h1234);
    // R6: user-mode writes ignored
    cycle(1, 0, 0, 20'h9000, 0, 0);
    cycle(1, 0, 1, 20'h0100, 1, 16'h0000);
    // R5: program partition; example mapping R2
    cycle(1, 1, 0, 20'h09000, 0, 0);
    cycle(1, 1, 1, 20'h02000, 0, 0);
    cycle(0, 0, 0, 0, 1, 16'h1204);
    check("R2 example", 32'(f_paddr(m_off, 16'h1204)), 32'h0A204);
    // R4: boundary
    cycle(0, 0, 0, 0, 1, 16'h1FFF);
    cycle(0, 0, 0, 0, 1, 16'h2000);
    cycle(0, 0, 0, 0, 1, 16'h2001);
    // R5: request in same cycle as span write uses old span
    cycle(1, 1, 1, 20'h00010, 1, 16'h0100);
    cycle(0, 0, 0, 0, 1, 16'h0100);
    // R5: same-cycle offset write uses old offset
    cycle(1, 1, 0, 20'hFFFF0, 1, 16'h0005);
    cycle(0, 0, 0, 0, 1, 16'h0005);
    // R6: user write then translation shows no change
    cycle(1, 0, 1, 20'hFFFFF, 0, 0);
    cycle(0, 0, 0, 0, 1, 16'h000F);
    cycle(0, 0, 0, 0, 1, 16'h0010);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom % 8;
      logic [LW-1:0] a;
      if (r == 0)
        cycle(1, ($urandom % 2) == 1, 1'b1, PW'($urandom % 64), 0, 0);
      else if (r == 1)
        cycle(1, ($urandom % 2) == 1, 1'b0, PW'($urandom), ($urandom % 2) == 1, LW'($urandom % 64));
      else begin
        int unsigned k = $urandom % 4;
        if (k == 0) a = m_span - 1;
        else if (k == 1) a = m_span;
        else if (k == 2) a = m_span + 1;
        else a = LW'($urandom % 80);
        cycle(0, 0, 0, 0, (r != 7), a);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule